// File: doc/BRIEF.md
# Configurable Event and Request Field

This block is a single field slice meant to be placed once per field inside a register-file slave. A parameter chooses one of six behaviours. Hardware can raise sticky event flags, or the same flags cleared when the field is read. Software writes can produce one-cycle request pulses, or request bits that stay held until hardware acknowledges them. Software can also queue a number of requests as a count. The last behaviour captures a hardware value only while a hardware enable is high. All six use one register-side access port with write enable, write data, byte strobes, read enable and read data. They also share a common set of hardware-side ports.

Bus protocol handling, address decoding and interrupt generation belong to the surrounding register file. `MODE` encodes the behaviour: 0 is sticky flag, 1 is clear-on-read flag, 2 is strobe, 3 is held request, 4 is counted request and 5 is latching status. The read data and request outputs come straight from registers, so read data is valid in the same cycle that `rd_en` is high.

Top module: `evt_req_field`

## Requirements
- R1: While `rst_n` is low, the internal state is zero, so `rd_data` and `hw_req` are both zero, in every mode.
- R2: In MODE 0, a bit high on `hw_in` at a clock edge makes the same bit of `rd_data` high from that edge on, and it stays high until it is cleared.
- R3: In MODE 0, an accepted write clears each field bit whose `wr_data` bit is 1 and whose byte strobe `wr_strb[i/8]` is 1. Bits written with 0, and bits in bytes with the strobe low, keep their value.
- R4: In MODE 0 and MODE 1, a hardware set and a software clear (write or read) of the same bit in the same cycle leave the bit set.
- R5: In MODE 1, a cycle with `rd_en` high clears every flag at the following edge, except bits set by `hw_in` in that cycle. Writes have no effect on the flags.
- R6: In MODE 2, an accepted write drives `hw_req` to `wr_data` masked by the byte strobes for exactly the one cycle after the write edge. `hw_req` is zero otherwise, and `rd_data` always reads zero.
- R7: In MODE 3, written 1 bits (byte-masked) set the matching `hw_req` bits. Each stays high until its `hw_ack` bit is high at an edge. A new write wins over an acknowledge of the same bit in the same cycle. `rd_data` equals `hw_req`.
- R8: In MODE 4, a write adds the byte-masked `wr_data` value to a pending count. `hw_ack[0]` at an edge with a nonzero count removes one. `rd_data` returns the count, and `hw_req[0]` is high exactly when the count is nonzero, with the other `hw_req` bits zero.
- R9: In MODE 4, the count after the net change of a cycle saturates at 2^WIDTH-1.
- R10: In MODE 5, `rd_data` takes the value of `hw_in` at each edge where `hw_latch_en` is high and otherwise holds. Writes are ignored and `hw_req` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write accepted this cycle |
| wr_data | input | WIDTH | Register write data |
| wr_strb | input | (WIDTH+7)/8 | Byte strobes for the write |
| rd_en | input | 1 | Register read accepted this cycle |
| rd_data | output | WIDTH | Field read value |
| hw_in | input | WIDTH | Hardware event bits or latch data |
| hw_ack | input | WIDTH | Hardware acknowledges (bit 0 only in MODE 4) |
| hw_latch_en | input | 1 | Hardware capture enable for MODE 5 |
| hw_req | output | WIDTH | Requests toward hardware |

## Verification
Two events can land on the same bit in the same cycle: a hardware set with a software clear, and a software request with a hardware acknowledge. A counted write can also land together with an acknowledge of the count. The bench forces these coincidences in directed steps. Examples are an event and a write-one-to-clear on the same flag bit, a read together with a new event in clear-on-read mode, and a write with an acknowledge on a full counter. It then drives long random streams, where such collisions happen often. A behavioural model updates on every edge using the set-wins and net-change-then-clamp rules. All six modes run side by side, and the model is compared against each mode's outputs on every cycle.

// File: rtl/evt_req_field.sv
module evt_req_field #(
  parameter int WIDTH = 16,
  parameter int MODE  = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WIDTH-1:0]           wr_data,
  input  logic [(WIDTH+7)/8-1:0]     wr_strb,
  input  logic                       rd_en,
  output logic [WIDTH-1:0]           rd_data,
  input  logic [WIDTH-1:0]           hw_in,
  input  logic [WIDTH-1:0]           hw_ack,
  input  logic                       hw_latch_en,
  output logic [WIDTH-1:0]           hw_req
);
  localparam logic [WIDTH-1:0] FULL = '1;

  logic [WIDTH-1:0] bmask, wbits, state, nxt;
  logic             unused_inputs;

  always_comb
    for (int i = 0; i < WIDTH; i++) bmask[i] = wr_strb[i/8];

  assign wbits = wr_en ? (wr_data & bmask) : '0;
  assign unused_inputs = ^{rd_en, hw_ack, hw_latch_en, hw_in, wbits};

  generate
    if (MODE == 0) begin : g_flag
      assign nxt = (state & ~wbits) | hw_in;
    end else if (MODE == 1) begin : g_vflag
      assign nxt = rd_en ? hw_in : (state | hw_in);
    end else if (MODE == 2) begin : g_strobe
      assign nxt = wbits;
    end else if (MODE == 3) begin : g_req
      assign nxt = (state & ~hw_ack) | wbits;
    end else if (MODE == 4) begin : g_mreq
      logic             dec;
      logic [WIDTH:0]   sum;
      assign dec = hw_ack[0] && (state != '0);
      assign sum = {1'b0, state} + {1'b0, wbits} - {{WIDTH{1'b0}}, dec};
      assign nxt = sum[WIDTH] ? FULL : sum[WIDTH-1:0];
    end else begin : g_latch
      assign nxt = hw_latch_en ? hw_in : state;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= '0;
    else        state <= nxt;

  assign rd_data = (MODE == 2) ? '0 : state;

  generate
    if (MODE == 2 || MODE == 3) begin : g_out_bits
      assign hw_req = state;
    end else if (MODE == 4) begin : g_out_cnt
      assign hw_req = {{(WIDTH-1){1'b0}}, state != '0};
    end else begin : g_out_none
      assign hw_req = '0;
    end
  endgenerate

  generate
    if (MODE == 0) begin : g_chk_flag
      assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data & $past(hw_in)) == $past(hw_in)));
      assert_unwritten_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (($past(rd_data) & ~rd_data) == '0));
    end else if (MODE == 1) begin : g_chk_vflag
      assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hw_in == '0) |=> (rd_data == '0));
      assert_set_beats_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data & $past(hw_in)) == $past(hw_in)));
    end else if (MODE == 2) begin : g_chk_strobe
      assert_pulse_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (hw_req == '0));
    end else if (MODE == 3) begin : g_chk_req
      assert_held_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hw_req) & ~$past(hw_ack) & ~hw_req) == '0));
    end else if (MODE == 4) begin : g_chk_mreq
      assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data == FULL && !hw_ack[0]) |=> (rd_data == FULL));
      assert_req_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hw_req) == ((rd_data != '0) ? 1 : 0));
    end else begin : g_chk_latch
      assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_latch_en |=> $stable(rd_data));
    end
  endgenerate
endmodule

// File: tb/evt_req_field_test.sv
`timescale 1ns/1ps
module evt_req_field_test;
  localparam int W = 16;
  localparam int NB = 2;
  localparam int NM = 6;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, hw_latch_en = 0;
  logic [W-1:0] wr_data = '0, hw_in = '0, hw_ack = '0;
  logic [NB-1:0] wr_strb = '0;
  logic [W-1:0] rd [NM];
  logic [W-1:0] req [NM];
  logic [W-1:0] m [NM];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  for (genvar g = 0; g < NM; g++) begin : g_mode
    evt_req_field #(.WIDTH(W), .MODE(g)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_strb(wr_strb), .rd_en(rd_en), .rd_data(rd[g]), .hw_in(hw_in),
      .hw_ack(hw_ack), .hw_latch_en(hw_latch_en), .hw_req(req[g]));
  end

  function automatic logic [W-1:0] wmask();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = wr_strb[i/8];
    return wr_en ? (wr_data & r) : '0;
  endfunction

  // behavioural reference, updated at every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NM; k++) m[k] = '0;
    end else begin
      logic [W-1:0] wb;
      longint s;
      wb = wmask();
      m[0] = (m[0] & ~wb) | hw_in;
      m[1] = rd_en ? hw_in : (m[1] | hw_in);
      m[2] = wb;
      m[3] = (m[3] & ~hw_ack) | wb;
      s = longint'(m[4]) + longint'(wb) - ((hw_ack[0] && m[4] != 0) ? 1 : 0);
      m[4] = (s > 65535) ? 16'hFFFF : W'(s);
      if (hw_latch_en) m[5] = hw_in;
    end
  end

  function automatic logic [W-1:0] exp_rd(int k);
    return (k == 2) ? '0 : m[k];
  endfunction

  function automatic logic [W-1:0] exp_req(int k);
    if (k == 2 || k == 3) return m[k];
    if (k == 4) return {15'd0, m[4] != 0};
    return '0;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  string rtag [NM] = '{"R2/R3/R4 flag", "R5 volatile", "R6 strobe",
                       "R7 request", "R8/R9 multi", "R10 latching"};

  always @(negedge clk) if (rst_n && !done) begin
    for (int k = 0; k < NM; k++) begin
      check({rtag[k], " rd_data"}, rd[k], exp_rd(k));
      check({rtag[k], " hw_req"}, req[k], exp_req(k));
    end
  end

  task automatic step(logic we, logic [W-1:0] wd, logic [NB-1:0] ws, logic re,
                      logic [W-1:0] hi, logic [W-1:0] ak, logic le);
    @(negedge clk);
    wr_en = we; wr_data = wd; wr_strb = ws; rd_en = re;
    hw_in = hi; hw_ack = ak; hw_latch_en = le;
  endtask

  task automatic idle();
    step(0, '0, '0, 0, '0, '0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < NM; k++) begin
      check("R1 reset rd_data", rd[k], '0);
      check("R1 reset hw_req", req[k], '0);
    end
    rst_n = 1;
    // R2: events set flags, latch captures
    step(0, '0, '0, 0, 16'h0101, '0, 1);
    idle();
    // R3: clear low byte only; bit 8 survives strobe mask
    step(1, 16'h0101, 2'b01, 0, '0, '0, 0);
    idle();
    // R4: set wins over write clear, and over read clear
    step(0, '0, '0, 0, 16'h0010, '0, 0);
    step(1, 16'h0010, 2'b11, 1, 16'h0010, '0, 0);
    idle();
    step(0, '0, '0, 1, '0, '0, 0);
    idle();
    // R6/R7: write pulses and held requests, ack with simultaneous re-write
    step(1, 16'h8421, 2'b11, 0, '0, '0, 0);
    idle();
    step(1, 16'h0001, 2'b11, 0, '0, 16'h0021, 0);
    step(0, '0, '0, 0, '0, 16'h8400, 0);
    // R8/R9: fill counter to saturation, then coincide write and ack
    step(1, 16'hFFFF, 2'b11, 0, '0, '0, 0);
    step(1, 16'h0003, 2'b01, 0, '0, '0, 0);
    step(1, 16'h0005, 2'b11, 0, '0, 16'h0001, 0);
    repeat (3) step(0, '0, '0, 0, '0, 16'h0001, 0);
    // R10: latch holds while enable low
    step(0, '0, '0, 0, 16'hBEEF, '0, 0);
    step(0, '0, '0, 0, 16'h1234, '0, 1);
    idle();
    // random streams
    for (int n = 0; n < 4000; n++)
      step(($urandom % 3) == 0, W'($urandom % ((n % 2) ? 8 : 65536)), NB'($urandom),
           ($urandom % 4) == 0, W'($urandom) & W'($urandom), W'($urandom),
           ($urandom % 3) == 0);
    idle();
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule